// File: doc/BRIEF.md
# PLL Control and Lock-Change Status Register

This block is one 8-bit register on a simple CPU bus that controls and monitors a clock-generation PLL. It holds four bits: an enable that switches the PLL loop and its VCO on, a select that picks the VCO as the base clock, an interrupt enable, and a sticky flag that records every change of the PLL lock indication. The lock input comes from the analog PLL domain, so it is synchronized before any edge is detected. When the flag and the interrupt enable are both set, an interrupt request goes to the CPU.

An automatic-mode input, driven by a companion bandwidth register, gates the interrupt features. While it is low, the interrupt enable cannot be written and both interrupt-related bits read as zero. The loop-enable bit is protected: software cannot switch the PLL off while the VCO is clocking the base clock. The flag is cleared by reading the register, so software collects a lock event simply by reading it.

Top module: `pll_ctl_reg`

## Requirements
- R1: After reset the register reads 0x2F when automatic mode is on: interrupt enable (bit 7) 0, lock-change flag (bit 6) 0, loop enable (bit 5) 1, clock select (bit 4) 0, bits 3..0 all 1; pllEnable is 1, baseClkSel is 0, irqReq is 0.
- R2: Only bus address 0x1C reaches the register: a write to another address changes nothing, and a read of another address returns 0x00.
- R3: Every change of lockIn, rising or falling, sets the flag (bit 6). The flag is set on the third rising clock edge after lockIn changes (two synchronizer stages, then the flag register).
- R4: A read of the register returns the current flag and clears it on that clock edge, so a second read returns bit 6 as 0.
- R5: When a lock change reaches the flag in the same cycle as a register read, the flag ends up set.
- R6: irqReq is 1 exactly while the flag, the interrupt enable and autoMode are all 1.
- R7: While autoMode is 0, writes to bit 7 are ignored, and bits 7 and 6 read as 0. The stored interrupt enable keeps its value and shows again when autoMode returns to 1.
- R8: Bit 5 is read/write and drives pllEnable. A write of 0 to bit 5 is ignored while the stored clock select (bit 4) is already 1.
- R9: Bit 4 is read/write and drives baseClkSel. Bits 3..0 always read 1 and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busAddr | input | 8 | Bus address |
| busWr | input | 1 | Write strobe, one cycle per write |
| busRd | input | 1 | Read strobe, one cycle per read |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational from address and register state |
| autoMode | input | 1 | Automatic mode from the bandwidth register |
| lockIn | input | 1 | PLL lock indication, asynchronous |
| irqReq | output | 1 | Interrupt request to the CPU |
| pllEnable | output | 1 | PLL loop and VCO enable |
| baseClkSel | output | 1 | Base clock select, 1 selects the VCO |

## Verification
Bus writes take effect on the clock edge that samples the strobe, so the bench reads back one cycle later; read data is combinational and is sampled in the strobe cycle itself, before the edge that clears the flag. A lock change needs three edges to reach the flag, so the bench waits four cycles before checking irqReq or reading, and for the collision case it places the read strobe exactly in the third-edge cycle. A sweep writes all 256 data values under both automatic-mode settings and compares each readback with a value computed from the previous write's clock-select bit.

// File: rtl/pll_ctl_pkg.sv
package pll_ctl_pkg;
  localparam int DATA_W     = 8;
  localparam int IRQEN_BIT  = 7;
  localparam int FLAG_BIT   = 6;
  localparam int LOOPON_BIT = 5;
  localparam int CLKSEL_BIT = 4;
  localparam int FILL_W     = CLKSEL_BIT;

  typedef struct packed {
    logic sel;
    logic wrHit;
    logic rdHit;
    logic lockToggle;
  } ctlStrobes_t;
endpackage

// File: rtl/pll_ctl_ctrl.sv
module pll_ctl_ctrl
  import pll_ctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h1C,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic              lockIn,
  output ctlStrobes_t       strobes
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic lockSync;
  logic lockPrev;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) syncQ[0] <= 1'b0;
          else        syncQ[0] <= lockIn;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) syncQ[g] <= 1'b0;
          else        syncQ[g] <= syncQ[g-1];
        end
      end
    end
  endgenerate

  assign lockSync = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lockPrev <= 1'b0;
    else        lockPrev <= lockSync;
  end

  always_comb begin
    strobes.sel        = (busAddr == REG_ADDR);
    strobes.wrHit      = strobes.sel & busWr;
    strobes.rdHit      = strobes.sel & busRd;
    strobes.lockToggle = lockSync ^ lockPrev;
  end

  // R3: a toggle strobe is a one-cycle event unless the input keeps moving
  a_r3_toggle_tracks_sync: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.lockToggle |=> (lockPrev != $past(lockPrev)));
endmodule

// File: rtl/pll_ctl_dp.sv
module pll_ctl_dp
  import pll_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobes_t       strobes,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              autoMode,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqReq,
  output logic              pllEnable,
  output logic              baseClkSel
);
  logic irqEn;
  logic lockChg;
  logic loopOn;
  logic vcoSel;
  logic [DATA_W-1:0] regView;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irqEn  <= 1'b0;
      loopOn <= 1'b1;
      vcoSel <= 1'b0;
    end else if (strobes.wrHit) begin
      if (autoMode) irqEn <= busWdata[IRQEN_BIT];
      loopOn <= busWdata[LOOPON_BIT] | vcoSel;
      vcoSel <= busWdata[CLKSEL_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  lockChg <= 1'b0;
    else if (strobes.lockToggle) lockChg <= 1'b1;
    else if (strobes.rdHit)      lockChg <= 1'b0;
  end

  always_comb begin
    regView = '0;
    regView[IRQEN_BIT]  = irqEn & autoMode;
    regView[FLAG_BIT]   = lockChg & autoMode;
    regView[LOOPON_BIT] = loopOn;
    regView[CLKSEL_BIT] = vcoSel;
    regView[FILL_W-1:0] = '1;
  end

  assign busRdata   = strobes.sel ? regView : '0;
  assign irqReq     = lockChg & irqEn & autoMode;
  assign pllEnable  = loopOn;
  assign baseClkSel = vcoSel;

  a_r3_flag_on_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.lockToggle |=> lockChg);
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.rdHit && !strobes.lockToggle) |=> !lockChg);
  a_r7_enable_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !autoMode |=> $stable(irqEn));
  a_r8_loop_interlock: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.wrHit && vcoSel) |=> loopOn);
  a_r2_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.wrHit |=> ($stable(loopOn) && $stable(vcoSel) && $stable(irqEn)));
endmodule

// File: rtl/pll_ctl_reg.sv
module pll_ctl_reg
  import pll_ctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h1C,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              autoMode,
  input  logic              lockIn,
  output logic              irqReq,
  output logic              pllEnable,
  output logic              baseClkSel
);
  ctlStrobes_t strobes;

  pll_ctl_ctrl #(
    .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWr(busWr),
    .busRd(busRd), .lockIn(lockIn), .strobes(strobes)
  );

  pll_ctl_dp u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .busWdata(busWdata),
    .autoMode(autoMode), .busRdata(busRdata), .irqReq(irqReq),
    .pllEnable(pllEnable), .baseClkSel(baseClkSel)
  );

  // R6: no request can leave the block with automatic mode off
  a_r6_irq_needs_auto: assert property (@(posedge clk) disable iff (!rst_n)
    irqReq |-> autoMode);
endmodule

// File: tb/pll_ctl_reg_tb.sv
module pll_ctl_reg_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] busAddr = 8'h1C;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic       autoMode = 1'b1;
  logic       lockIn = 1'b0;
  logic       irqReq, pllEnable, baseClkSel;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pll_ctl_reg u_dut (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .autoMode(autoMode),
    .lockIn(lockIn), .irqReq(irqReq), .pllEnable(pllEnable), .baseClkSel(baseClkSel)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [7:0] v);
    @(negedge clk);
    busAddr = a; busWdata = v; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0; busAddr = 8'h1C;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 v = busRdata;
    @(negedge clk);
    busRd = 1'b0; busAddr = 8'h1C;
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    logic expEn, expOn, expSel;
    waitCycles(3);
    rst_n = 1'b1;
    waitCycles(1);

    // R1 reset state
    check("R1 pllEnable", pllEnable, 1);
    check("R1 baseClkSel", baseClkSel, 0);
    check("R1 irqReq", irqReq, 0);
    busRead(8'h1C, rv);
    check("R1 reset value", rv, 8'h2F);

    // R2 other address
    busWrite(8'h1D, 8'h90);
    busRead(8'h1D, rv);
    check("R2 foreign read", rv, 8'h00);
    busRead(8'h1C, rv);
    check("R2 foreign write ignored", rv, 8'h2F);

    // Sweep: R7 R8 R9 with model
    expEn = 1'b0; expOn = 1'b1; expSel = 1'b0;
    for (int m = 0; m < 2; m++) begin
      autoMode = (m == 1);
      for (int v = 0; v < 256; v++) begin
        busWrite(8'h1C, 8'(v));
        if (autoMode) expEn = v[7];
        expOn = v[5] | expSel;
        expSel = v[4];
        busRead(8'h1C, rv);
        check("R7 R8 R9 sweep readback", rv,
              {expEn & autoMode, 1'b0, expOn, expSel, 4'hF});
        check("R8 pllEnable", pllEnable, expOn);
        check("R9 baseClkSel", baseClkSel, expSel);
      end
    end

    // R7 stored enable reappears
    autoMode = 1'b1;
    busWrite(8'h1C, 8'hA0);
    autoMode = 1'b0;
    busWrite(8'h1C, 8'h20);
    autoMode = 1'b1;
    busRead(8'h1C, rv);
    check("R7 enable kept through auto off", rv, 8'hAF);

    // R3 rising edge, R6 irq
    lockIn = 1'b1;
    waitCycles(2);
    check("R3 flag not yet set", irqReq, 0);
    waitCycles(2);
    check("R6 irq on flag and enable", irqReq, 1);
    autoMode = 1'b0;
    #1 check("R6 irq masked by auto", irqReq, 0);
    busRead(8'h1C, rv);
    check("R7 bits masked", rv, 8'h2F);
    autoMode = 1'b1;
    busRead(8'h1C, rv);
    check("R4 read while masked cleared flag", rv, 8'hAF);

    // R3 falling edge, R4 clear
    lockIn = 1'b0;
    waitCycles(4);
    check("R3 falling sets irq", irqReq, 1);
    busRead(8'h1C, rv);
    check("R4 first read sees flag", rv, 8'hEF);
    busRead(8'h1C, rv);
    check("R4 second read clear", rv, 8'hAF);
    check("R6 irq dropped", irqReq, 0);

    // R6 enable off keeps irq low
    busWrite(8'h1C, 8'h20);
    lockIn = 1'b1;
    waitCycles(4);
    check("R6 no irq without enable", irqReq, 0);
    busRead(8'h1C, rv);
    check("R3 flag set rising again", rv, 8'h6F);

    // R5 collision: read in the cycle the flag sets
    @(negedge clk);
    lockIn = 1'b0;
    @(negedge clk);
    busRead(8'h1C, rv);
    check("R5 collision read saw old flag", rv, 8'h2F);
    busRead(8'h1C, rv);
    check("R5 set wins over read", rv, 8'h6F);
    busRead(8'h1C, rv);
    check("R4 clear after collision", rv, 8'h2F);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule